// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects one-cycle request pulses from a set of peripherals and decides when a small processor core should leave its instruction stream for a service routine. Each source has a sticky pending flag and an enable bit. A single global enable gates all sources. When the core reports an instruction boundary and an enabled source is pending while the global enable is on, the block selects the source with the lowest index. It tells the core to save its program counter, then hands over that source's vector address.

Accepting a request clears the global enable and the serviced source's flag. A return strobe from the core sets the global enable again. Software can set it earlier from inside a routine, which allows nesting. Reset owns the top vector slot at address 0. After reset it is served first, without a program-counter save and whatever the enable state. A small register port lets software read and write the global enable, the enable mask and the pending flags.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the global enable, all enable bits and all pending flags read as zero, and a reset request is outstanding.
- R2: The first sequence after reset presents vector address 0 and gives no program-counter save strobe. It is taken even with the global enable at 0.
- R3: A one-cycle high on `src_pulse[k]` sets flag k. The flag stays set until it is serviced or software writes a 1 to bit k with selector 2. Writing a 1 to bit k with selector 3 sets flag k.
- R4: Source k is accepted only when its enable bit and the global enable are both 1. Otherwise it stays pending.
- R5: When several enabled sources are pending, the lowest index is served first.
- R6: Peripheral source k has vector address 4*(k+1). Slots are spaced four bytes apart above the reset slot.
- R7: `push_pc` is high for the one cycle after the accepting edge. `vec_valid` is high, with the address, for exactly one cycle, four edges after acceptance.
- R8: Acceptance clears the global enable and the accepted flag. Every other pending flag keeps its value.
- R9: A one-cycle `reti` sets the global enable, so that held requests are then taken in priority order.
- R10: Writing 1 to the global enable inside a service routine lets a further request be accepted (nesting).
- R11: A sequence starts only on a clock edge where `fetch_ready` is high. A sequence in progress finishes unchanged and is not restarted, whatever requests or writes arrive meanwhile.
- R12: Register selector 0 reads the global enable in bit 0, selector 1 reads the enable mask, and selectors 2 and 3 read the pending flags. A write with selector 0 loads bit 0 into the global enable, and a write with selector 1 loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | N_SRC | One-cycle request pulses, one per source |
| fetch_ready | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data (combinational) |
| push_pc | output | 1 | Save program counter strobe |
| vec_valid | output | 1 | Vector address valid strobe |
| vec_addr | output | VEC_W | Vector address |

## Verification
A wrong global enable shows at once. A request is either taken when it should be held, which is a `push_pc` one edge after a `fetch_ready` cycle, or it is held when it should be taken. Selector 0 also exposes the enable directly. A flag that is wrongly kept or dropped shows on the selector 2 read at the next cycle, and also as a repeated or missing sequence. A priority or slot error shows four edges after acceptance as a wrong `vec_addr`. The sweeps cover every single source and every pair of sources, so any such error appears within one sequence.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_WAIT1,
    ST_WAIT2,
    ST_VEC
  } vic_state_t;

  localparam logic [1:0] SEL_GCTL = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_PCLR = 2'd2;
  localparam logic [1:0] SEL_PSET = 2'd3;

  // slot 0 is reset, slot k+1 is peripheral k
  function automatic int unsigned slot_to_addr(input int unsigned slot);
    return slot * 4;
  endfunction

endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [N_SRC-1:0] reg_wdata,
  input  logic [N_SRC-1:0] ack_onehot,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] mask_q
);
  import vic_pkg::*;

  logic [N_SRC-1:0] sw_clr;
  logic [N_SRC-1:0] sw_set;

  assign sw_clr = (reg_wr && reg_sel == SEL_PCLR) ? reg_wdata : '0;
  assign sw_set = (reg_wr && reg_sel == SEL_PSET) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (reg_wr && reg_sel == SEL_MASK)
      mask_q <= reg_wdata;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend_q[i] <= 1'b0;
      else if (src_pulse[i] || sw_set[i])
        pend_q[i] <= 1'b1;
      else if (ack_onehot[i] || sw_clr[i])
        pend_q[i] <= 1'b0;
    end

    AST_FLAG_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_onehot[i] && !src_pulse[i] && !sw_set[i] |=> !pend_q[i]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] && !ack_onehot[i] && !sw_clr[i] |=> pend_q[i]); // R3
  end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] grant
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    grant = found ? (N_SRC'(1) << idx) : '0;
  end

endmodule

// File: rtl/vic_seq.sv
module vic_seq #(
  parameter int IDX_W  = 3,
  parameter int SLOT_W = 4,
  parameter int VEC_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_ready,
  input  logic             reti,
  input  logic             gie_wr,
  input  logic             gie_wdata,
  input  logic             per_found,
  input  logic [IDX_W-1:0] per_idx,
  output logic             accept,
  output logic             accept_per,
  output logic             gie_q,
  output logic             push_pc,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr
);
  import vic_pkg::*;

  vic_state_t        st_q, st_d;
  logic              rst_pend_q;
  logic [SLOT_W-1:0] slot_q;
  logic              want;

  assign want       = rst_pend_q || (gie_q && per_found);
  assign accept     = (st_q == ST_IDLE) && fetch_ready && want;
  assign accept_per = accept && !rst_pend_q;

  always_comb begin
    unique case (st_q)
      ST_IDLE:  st_d = accept ? ST_PUSH : ST_IDLE;
      ST_PUSH:  st_d = ST_WAIT1;
      ST_WAIT1: st_d = ST_WAIT2;
      ST_WAIT2: st_d = ST_VEC;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rst_pend_q <= 1'b1;
      slot_q     <= '0;
      gie_q      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        rst_pend_q <= 1'b0;
        slot_q     <= rst_pend_q ? '0 : SLOT_W'(per_idx) + SLOT_W'(1);
      end
      if (accept)
        gie_q <= 1'b0;
      else if (gie_wr)
        gie_q <= gie_wdata;
      else if (reti)
        gie_q <= 1'b1;
    end
  end

  assign push_pc   = (st_q == ST_PUSH) && (slot_q != '0);
  assign vec_valid = (st_q == ST_VEC);
  assign vec_addr  = vec_valid ? VEC_W'(slot_to_addr(int'(slot_q))) : '0;

  AST_PUSH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_per |=> push_pc); // R7
  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R7
  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie_q); // R8
  AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !accept && !gie_wr |=> gie_q); // R9
  AST_START_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_pc) |-> $past(fetch_ready)); // R11
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc |=> !push_pc); // R11

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_SRC = 8,
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int SLOT_W = $clog2(N_SRC + 1),
  localparam int VEC_W  = SLOT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic             fetch_ready,
  input  logic             reti,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             push_pc,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr
);
  import vic_pkg::*;

  logic [N_SRC-1:0] pend_q, mask_q, live_req, grant, ack_onehot;
  logic             per_found, accept, accept_per, gie_q;
  logic [IDX_W-1:0] per_idx;

  assign live_req   = pend_q & mask_q;
  assign ack_onehot = accept_per ? grant : '0;

  vic_pend_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ack_onehot(ack_onehot), .pend_q(pend_q), .mask_q(mask_q)
  );

  vic_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req(live_req), .found(per_found), .idx(per_idx), .grant(grant)
  );

  vic_seq #(.IDX_W(IDX_W), .SLOT_W(SLOT_W), .VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready), .reti(reti),
    .gie_wr(reg_wr && reg_sel == SEL_GCTL), .gie_wdata(reg_wdata[0]),
    .per_found(per_found), .per_idx(per_idx),
    .accept(accept), .accept_per(accept_per), .gie_q(gie_q),
    .push_pc(push_pc), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  always_comb begin
    case (reg_sel)
      SEL_GCTL: reg_rdata = {{(N_SRC-1){1'b0}}, gie_q};
      SEL_MASK: reg_rdata = mask_q;
      default:  reg_rdata = pend_q;
    endcase
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~live_req) == '0); // R4
  AST_ACK_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_per |-> gie_q && (ack_onehot & ~mask_q) == '0); // R4

endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  localparam int N = 8;
  localparam int VW = $clog2(N + 1) + 2;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  src_pulse = '0;
  logic          fetch_ready = 0;
  logic          reti = 0;
  logic          reg_wr = 0;
  logic [1:0]    reg_sel = 0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          push_pc, vec_valid;
  logic [VW-1:0] vec_addr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N)) i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .fetch_ready(fetch_ready),
    .reti(reti), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .push_pc(push_pc), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [N-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] sel, output int v);
    reg_sel = sel;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_pulse = m;
    tick();
    src_pulse = '0;
  endtask

  task automatic strobe_reti();
    reti = 1;
    tick();
    reti = 0;
  endtask

  // accept on the first edge, vector on the fourth edge after it
  task automatic run_seq(input int exp_addr, input int exp_push, input string tag);
    fetch_ready = 1;
    tick();
    fetch_ready = 0;
    check({tag, " push"}, push_pc, exp_push);
    check({tag, " early valid"}, vec_valid, 0);
    tick();
    check({tag, " push one cycle"}, push_pc, 0);
    tick();
    tick();
    check({tag, " valid"}, vec_valid, 1);
    check({tag, " addr"}, vec_addr, exp_addr);
    tick();
    check({tag, " valid one cycle"}, vec_valid, 0);
  endtask

  task automatic hold_no_take(input int cycles, input string tag);
    fetch_ready = 1;
    for (int c = 0; c < cycles; c++) begin
      tick();
      check(tag, push_pc | vec_valid, 0);
    end
    fetch_ready = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    tick(); tick(); tick();
    rst_n = 1;

    // R1: reset state
    rreg(0, v); check("R1 gie", v, 0);
    rreg(1, v); check("R1 mask", v, 0);
    rreg(2, v); check("R1 pend", v, 0);

    // R11: nothing starts without fetch_ready
    for (int c = 0; c < 3; c++) begin
      tick();
      check("R11 idle without fetch", push_pc | vec_valid, 0);
    end

    // R2: reset slot first, no save, gie off
    run_seq(0, 0, "R2 reset slot");
    rreg(0, v); check("R2 gie stays 0", v, 0);

    // R12: register map
    wreg(1, 8'hA5);
    rreg(1, v); check("R12 mask readback", v, 'hA5);
    wreg(1, '1);

    // R3 / R4: pending kept while gie off
    pulse(8'h08);
    rreg(2, v); check("R3 flag set by pulse", v, 'h08);
    hold_no_take(5, "R4 gie off holds");
    rreg(2, v); check("R4 still pending", v, 'h08);

    // R6 / R8 / R9: sweep of single sources
    for (int k = 0; k < N; k++) begin
      wreg(2, '1);
      pulse(N'(1) << k);
      wreg(0, 1);
      run_seq(4 * (k + 1), 1, "R6 single source");
      rreg(2, v); check("R8 flag cleared", v, 0);
      rreg(0, v); check("R8 gie cleared", v, 0);
      strobe_reti();
      rreg(0, v); check("R9 reti sets gie", v, 1);
      wreg(0, 0);
    end

    // R5: every pair
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        wreg(2, '1);
        pulse((N'(1) << a) | (N'(1) << b));
        wreg(0, 1);
        run_seq(4 * (a + 1), 1, "R5 lower index wins");
        rreg(2, v); check("R8 other flag kept", v, 1 << b);
      end
    end
    wreg(2, '1);
    wreg(0, 0);

    // R4: enable mask
    wreg(1, 8'hFD);
    pulse(8'h06);
    wreg(0, 1);
    run_seq(12, 1, "R4 masked source skipped");
    rreg(2, v); check("R4 masked flag kept", v, 'h02);
    wreg(0, 1);
    hold_no_take(4, "R4 masked not taken");
    wreg(0, 0);
    wreg(2, '1);
    wreg(1, '1);

    // R3: software clear and set
    pulse(8'h81);
    wreg(2, 8'h01);
    rreg(2, v); check("R3 write-1 clear", v, 'h80);
    wreg(3, 8'h04);
    rreg(2, v); check("R3 write-1 set", v, 'h84);
    wreg(2, '1);

    // R9: held requests taken in order after reti
    pulse(8'h24);
    tick();
    strobe_reti();
    run_seq(12, 1, "R9 first held");
    strobe_reti();
    run_seq(24, 1, "R9 second held");
    rreg(2, v); check("R9 all served", v, 0);

    // R10: nesting by software enable
    wreg(0, 1);
    pulse(8'h40);
    run_seq(28, 1, "R10 outer");
    pulse(8'h02);
    hold_no_take(3, "R10 blocked before enable");
    wreg(0, 1);
    run_seq(8, 1, "R10 nested");
    wreg(0, 0);

    // R11: no cancel, no restart
    wreg(2, '1);
    wreg(0, 1);
    pulse(8'h20);
    fetch_ready = 1;
    tick();
    check("R11 start", push_pc, 1);
    src_pulse = 8'h01; reg_sel = 0; reg_wdata = 8'h01; reg_wr = 1;
    tick();
    src_pulse = '0; reg_wr = 0; reg_wdata = '0;
    check("R11 no restart", push_pc | vec_valid, 0);
    tick();
    check("R11 no restart 2", push_pc | vec_valid, 0);
    tick();
    check("R11 kept valid", vec_valid, 1);
    check("R11 kept addr", vec_addr, 24);
    tick();
    check("R11 back idle", push_pc | vec_valid, 0);
    tick();
    fetch_ready = 0;
    check("R11 next start", push_pc, 1);
    tick(); tick(); tick();
    check("R11 next addr", vec_addr, 4);
    check("R11 next valid", vec_valid, 1);
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule